// File: doc/BRIEF.md
# Timer Trigger-Output Mode Selector

This block produces the two trigger outputs of a general-purpose timer: a primary trigger and an optional secondary trigger. Each output has its own mode field in a 32-bit control word. The mode field picks what drives that output. The choices are a counter event (reset, enable level, update, channel-1 compare), a compare reference waveform passed straight through, or a one-cycle pulse made from edges of one or two reference waveforms. The counter, prescaler, compare channels and pin logic sit outside the block and drive it through plain inputs.

Software writes the control word through a simple write strobe and reads it back combinationally. An instance built without the secondary output ignores writes to that field and reads it back as zero. Software can therefore write all ones to the field and test the read value for nonzero to find out whether the secondary trigger exists.

Every trigger output is registered. Its value in cycle t+1 is the selected source as sampled in cycle t. Edges are found by comparing each reference input with its own copy registered one cycle earlier.

Top module: `trig_out_select`

## Requirements
- R1: A synchronous reset clears both mode fields to 0, so the whole control word reads 0, and drives both trigger outputs low in the cycle after the reset edge.
- R2: The primary mode is the 3-bit field at control bits 6:4 and the secondary mode is the 4-bit field at bits 23:20. All other control bits read 0. A write takes effect at the next clock edge and reads back at once after it.
- R3: Modes 0 to 3 select, in order, the counter reset event, the counter enable level, the counter update event and the channel-1 compare event. The output equals that input as sampled one cycle earlier. This applies on both outputs.
- R4: Modes 4 to 7 pass reference waveforms 1 to 4 (ref_i bits 0 to 3) to the output with one cycle of latency. This applies on both outputs.
- R5: Secondary modes 8 and 9 pass reference waveforms 5 and 6 (ref_i bits 4 and 5) to the secondary output with one cycle of latency.
- R6: Secondary mode 10 pulses for one cycle after each rising or falling edge of reference 4. Mode 11 does the same for reference 6.
- R7: Secondary modes 12 to 15 pulse for one cycle after an edge of one of two sources. The sources are: 12, reference 4 rising or reference 6 rising; 13, reference 4 rising or reference 6 falling; 14, reference 5 rising or reference 6 rising; 15, reference 5 rising or reference 6 falling.
- R8: When both qualifying edges of a two-source mode fall in the same cycle, the secondary output gives one single-cycle pulse.
- R9: With HAS_SEC set to 0, writes to bits 23:20 are ignored, the field reads 0 and the secondary output stays low. The primary output behaves as it does with the secondary output present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| ev_cnt_reset | input | 1 | Counter reset event pulse |
| ev_cnt_enable | input | 1 | Counter enable level |
| ev_cnt_update | input | 1 | Counter update event pulse |
| ev_cc1 | input | 1 | Channel-1 compare event pulse |
| ref_i | input | 6 | Compare reference waveforms 1 to 6 (bit 0 is reference 1) |
| trig_pri | output | 1 | Primary trigger output |
| trig_sec | output | 1 | Secondary trigger output |

## Verification
The assertions check in every cycle that the outputs are low just after reset. They also check that the update, compare and enable modes follow their event one cycle late, and that the pass-through modes follow their reference. The edge-pulse modes depend on reference history across two cycles, so only the bench scenarios show them. Those scenarios sweep all sixteen secondary modes under pseudo-random stimulus, drive coincident edges, test the all-ones probe on an instance without the secondary output, and apply a reset in the middle of activity.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;

   localparam int CTRL_W = 32;
   localparam int NUM_REF = 6;

   typedef enum logic [3:0] {
      TM_RESET     = 4'd0,
      TM_ENABLE    = 4'd1,
      TM_UPDATE    = 4'd2,
      TM_CMP_PULSE = 4'd3,
      TM_REF1      = 4'd4,
      TM_REF2      = 4'd5,
      TM_REF3      = 4'd6,
      TM_REF4      = 4'd7,
      TM_REF5      = 4'd8,
      TM_REF6      = 4'd9,
      TM_EDGE4     = 4'd10,
      TM_EDGE6     = 4'd11,
      TM_R4_R6     = 4'd12,
      TM_R4_F6     = 4'd13,
      TM_R5_R6     = 4'd14,
      TM_R5_F6     = 4'd15
   } trig_mode_e;

   typedef struct packed {
      logic cc1;
      logic update;
      logic enable;
      logic cnt_reset;
   } trig_evt_t;

endpackage

// File: rtl/trig_ctrl_reg.sv
module trig_ctrl_reg #(
   parameter int CW      = 32,
   parameter int PRI_LSB = 4,
   parameter int PRI_W   = 3,
   parameter int SEC_LSB = 20,
   parameter int SEC_W   = 4,
   parameter bit HAS_SEC = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CW-1:0]    wr_data,
   output logic [CW-1:0]    rd_data,
   output logic [PRI_W-1:0] pri_mode,
   output logic [SEC_W-1:0] sec_mode
);

   localparam int PRI_MSB = PRI_LSB + PRI_W - 1;
   localparam int SEC_MSB = SEC_LSB + SEC_W - 1;

   if (PRI_MSB >= CW || SEC_MSB >= CW) begin : g_bad_fit
      $error("trig_ctrl_reg: mode field outside control word");
   end
   if (!(SEC_LSB > PRI_MSB || SEC_MSB < PRI_LSB)) begin : g_bad_overlap
      $error("trig_ctrl_reg: mode fields overlap");
   end

   logic [PRI_W-1:0] pri_q;

   always_ff @(posedge clk) begin
      if (rst)        pri_q <= '0;
      else if (wr_en) pri_q <= wr_data[PRI_LSB +: PRI_W];
   end
   assign pri_mode = pri_q;

   if (HAS_SEC) begin : g_sec_field
      logic [SEC_W-1:0] sec_q;
      always_ff @(posedge clk) begin
         if (rst)        sec_q <= '0;
         else if (wr_en) sec_q <= wr_data[SEC_LSB +: SEC_W];
      end
      assign sec_mode = sec_q;
   end else begin : g_no_sec_field
      assign sec_mode = '0;
   end

   always_comb begin
      rd_data = '0;
      rd_data[PRI_LSB +: PRI_W] = pri_q;
      rd_data[SEC_LSB +: SEC_W] = sec_mode;
   end

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] sig_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   if (N < 1) begin : g_bad_n
      $error("trig_edge_det: N must be positive");
   end

   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= sig_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign rise_o[i] =  sig_i[i] & ~prev_q[i];
      assign fall_o[i] = ~sig_i[i] &  prev_q[i];
   end

endmodule

// File: rtl/trig_mode_mux.sv
module trig_mode_mux
   import trig_sel_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter int NREF   = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode,
   input  trig_evt_t         evt,
   input  logic [NREF-1:0]   ref_lvl,
   input  logic [NREF-1:0]   ref_rise,
   input  logic [NREF-1:0]   ref_fall,
   output logic              trig_o
);

   localparam int FULL_W = 4;

   if (MODE_W < 3 || MODE_W > FULL_W) begin : g_bad_w
      $error("trig_mode_mux: MODE_W must be 3 or 4");
   end
   if (NREF != 6) begin : g_bad_nref
      $error("trig_mode_mux: six reference inputs expected");
   end

   trig_mode_e sel;
   logic       nxt;

   assign sel = trig_mode_e'({{(FULL_W-MODE_W){1'b0}}, mode});

   always_comb begin
      unique case (sel)
         TM_RESET:     nxt = evt.cnt_reset;
         TM_ENABLE:    nxt = evt.enable;
         TM_UPDATE:    nxt = evt.update;
         TM_CMP_PULSE: nxt = evt.cc1;
         TM_REF1:      nxt = ref_lvl[0];
         TM_REF2:      nxt = ref_lvl[1];
         TM_REF3:      nxt = ref_lvl[2];
         TM_REF4:      nxt = ref_lvl[3];
         TM_REF5:      nxt = ref_lvl[4];
         TM_REF6:      nxt = ref_lvl[5];
         TM_EDGE4:     nxt = ref_rise[3] | ref_fall[3];
         TM_EDGE6:     nxt = ref_rise[5] | ref_fall[5];
         TM_R4_R6:     nxt = ref_rise[3] | ref_rise[5];
         TM_R4_F6:     nxt = ref_rise[3] | ref_fall[5];
         TM_R5_R6:     nxt = ref_rise[4] | ref_rise[5];
         TM_R5_F6:     nxt = ref_rise[4] | ref_fall[5];
         default:      nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) trig_o <= 1'b0;
      else     trig_o <= nxt;
   end

endmodule

// File: rtl/trig_out_select.sv
module trig_out_select
   import trig_sel_pkg::*;
#(
   parameter int CW      = 32,
   parameter int PRI_LSB = 4,
   parameter int PRI_W   = 3,
   parameter int SEC_LSB = 20,
   parameter int SEC_W   = 4,
   parameter bit HAS_SEC = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] rd_data,
   input  logic          ev_cnt_reset,
   input  logic          ev_cnt_enable,
   input  logic          ev_cnt_update,
   input  logic          ev_cc1,
   input  logic [5:0]    ref_i,
   output logic          trig_pri,
   output logic          trig_sec
);

   localparam int NREF = NUM_REF;

   logic [PRI_W-1:0] pri_mode;
   logic [SEC_W-1:0] sec_mode;
   logic [NREF-1:0]  rise;
   logic [NREF-1:0]  fall;
   trig_evt_t        evt;

   assign evt = '{cc1: ev_cc1, update: ev_cnt_update,
                  enable: ev_cnt_enable, cnt_reset: ev_cnt_reset};

   trig_ctrl_reg #(
      .CW(CW), .PRI_LSB(PRI_LSB), .PRI_W(PRI_W),
      .SEC_LSB(SEC_LSB), .SEC_W(SEC_W), .HAS_SEC(HAS_SEC)
   ) u_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pri_mode(pri_mode), .sec_mode(sec_mode)
   );

   trig_edge_det #(.N(NREF)) u_edge (
      .clk(clk), .rst(rst), .sig_i(ref_i), .rise_o(rise), .fall_o(fall)
   );

   trig_mode_mux #(.MODE_W(PRI_W), .NREF(NREF)) u_pri_mux (
      .clk(clk), .rst(rst), .mode(pri_mode), .evt(evt),
      .ref_lvl(ref_i), .ref_rise(rise), .ref_fall(fall), .trig_o(trig_pri)
   );

   if (HAS_SEC) begin : g_sec_out
      trig_mode_mux #(.MODE_W(SEC_W), .NREF(NREF)) u_sec_mux (
         .clk(clk), .rst(rst), .mode(sec_mode), .evt(evt),
         .ref_lvl(ref_i), .ref_rise(rise), .ref_fall(fall), .trig_o(trig_sec)
      );
   end else begin : g_no_sec_out
      assign trig_sec = 1'b0;
   end

endmodule

// File: rtl/trig_out_select_chk.sv
module trig_out_select_chk #(
   parameter int CW      = 32,
   parameter int PRI_LSB = 4,
   parameter int PRI_W   = 3,
   parameter int SEC_LSB = 20,
   parameter int SEC_W   = 4,
   parameter bit HAS_SEC = 1'b1
) (
   input logic          clk,
   input logic          rst,
   input logic [CW-1:0] rd_data,
   input logic          ev_cnt_enable,
   input logic          ev_cnt_update,
   input logic          ev_cc1,
   input logic [5:0]    ref_i,
   input logic          trig_pri,
   input logic          trig_sec
);

   logic [PRI_W-1:0] pri_f;
   logic [SEC_W-1:0] sec_f;
   assign pri_f = rd_data[PRI_LSB +: PRI_W];
   assign sec_f = rd_data[SEC_LSB +: SEC_W];

   // R1
   reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (rd_data == '0 && !trig_pri && !trig_sec));

   // R3
   pri_update_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (pri_f == PRI_W'(2)) |=> (trig_pri == $past(ev_cnt_update)));

   // R3
   pri_enable_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (pri_f == PRI_W'(1)) |=> (trig_pri == $past(ev_cnt_enable)));

   // R3
   pri_compare_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (pri_f == PRI_W'(3)) |=> (trig_pri == $past(ev_cc1)));

   // R4
   pri_ref1_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (pri_f == PRI_W'(4)) |=> (trig_pri == $past(ref_i[0])));

   // R5
   sec_ref5_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (sec_f == SEC_W'(8)) |=> (trig_sec == $past(ref_i[4])));

endmodule

bind trig_out_select trig_out_select_chk #(
   .CW(CW), .PRI_LSB(PRI_LSB), .PRI_W(PRI_W),
   .SEC_LSB(SEC_LSB), .SEC_W(SEC_W), .HAS_SEC(HAS_SEC)
) u_chk (
   .clk(clk), .rst(rst), .rd_data(rd_data),
   .ev_cnt_enable(ev_cnt_enable), .ev_cnt_update(ev_cnt_update),
   .ev_cc1(ev_cc1), .ref_i(ref_i), .trig_pri(trig_pri), .trig_sec(trig_sec)
);

// File: tb/test_trig_out_select.sv
module test_trig_out_select;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        ev_rst = 1'b0, ev_en = 1'b0, ev_upd = 1'b0, ev_cmp = 1'b0;
   logic [5:0]  refs = '0;
   logic [31:0] rd_a, rd_b;
   logic        pri_a, sec_a, pri_b, sec_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   trig_out_select #(.HAS_SEC(1'b1)) i_trig_out_select (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
      .ev_cnt_reset(ev_rst), .ev_cnt_enable(ev_en), .ev_cnt_update(ev_upd),
      .ev_cc1(ev_cmp), .ref_i(refs), .trig_pri(pri_a), .trig_sec(sec_a)
   );

   trig_out_select #(.HAS_SEC(1'b0)) i_trig_out_select_nosec (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
      .ev_cnt_reset(ev_rst), .ev_cnt_enable(ev_en), .ev_cnt_update(ev_upd),
      .ev_cc1(ev_cmp), .ref_i(refs), .trig_pri(pri_b), .trig_sec(sec_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected output from the requirements: ev = {cmp, upd, en, rst}
   function automatic logic model(input int m, input logic [3:0] ev,
                                  input logic [5:0] r, input logic [5:0] p);
      logic [5:0] ri, fa;
      ri = r & ~p;
      fa = ~r & p;
      if (m <= 3) return ev[m];
      if (m <= 9) return r[m-4];
      case (m)
         10: return ri[3] | fa[3];
         11: return ri[5] | fa[5];
         12: return ri[3] | ri[5];
         13: return ri[3] | fa[5];
         14: return ri[4] | ri[5];
         default: return ri[4] | fa[5];
      endcase
   endfunction

   function automatic string req_of(input int m);
      if (m <= 3)  return "R3";
      if (m <= 7)  return "R4";
      if (m <= 9)  return "R5";
      if (m <= 11) return "R6";
      return "R7";
   endfunction

   task automatic zero_inputs();
      {ev_rst, ev_en, ev_upd, ev_cmp} = '0;
      refs = '0;
   endtask

   // Called at a negedge; returns at a negedge with the new word live.
   task automatic write_ctrl(input logic [31:0] v);
      zero_inputs();
      wr_en = 1'b1;
      wr_data = v;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic sweep(input int pm, input int sm, input int cycles);
      logic [5:0] prev;
      logic [3:0] ev;
      write_ctrl((32'(sm) << 20) | (32'(pm) << 4));
      prev = '0;
      for (int c = 0; c < cycles; c++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ev = lfsr[3:0];
         {ev_cmp, ev_upd, ev_en, ev_rst} = ev;
         refs = lfsr[15:10] ^ {lfsr[4], lfsr[7], lfsr[5], lfsr[9], lfsr[6], lfsr[8]};
         @(posedge clk);
         @(negedge clk);
         chk(req_of(pm), 32'(pri_a), 32'(model(pm, ev, refs, prev)));
         chk(req_of(sm), 32'(sec_a), 32'(model(sm, ev, refs, prev)));
         chk("R9", 32'(pri_b), 32'(model(pm, ev, refs, prev)));
         chk("R9", 32'(sec_b), 32'd0);
         prev = refs;
      end
   endtask

   task automatic step_refs(input logic [5:0] r);
      refs = r;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      // R1: reset state with stimulus active
      wr_en = 1'b1;
      wr_data = 32'hFFFF_FFFF;
      refs = 6'h3F;
      ev_rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", rd_a, 32'd0);
      chk("R1", 32'(pri_a), 32'd0);
      chk("R1", 32'(sec_a), 32'd0);
      wr_en = 1'b0;
      zero_inputs();
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R2: field placement, other bits zero
      write_ctrl(32'h1234_5678);
      chk("R2", rd_a, (((32'h1234_5678 >> 20) & 32'hF) << 20) | (((32'h1234_5678 >> 4) & 32'h7) << 4));
      write_ctrl(32'hFFFF_FFFF);
      chk("R2", rd_a, 32'h00F0_0070);
      // R9: probe on instance without secondary output
      chk("R9", rd_b & 32'h00F0_0000, 32'd0);
      chk("R9", rd_b, 32'h0000_0070);
      write_ctrl(32'h0);
      chk("R2", rd_a, 32'd0);

      // R3..R7: every secondary mode, primary modes cycled
      for (int s = 0; s < 16; s++) sweep(s % 8, s, 40);
      for (int s = 0; s < 16; s++) sweep(7 - (s % 8), 15 - s, 24);

      // R8: coincident edges in a two-source mode give one pulse
      write_ctrl(32'd12 << 20);
      step_refs(6'b101000);
      chk("R8", 32'(sec_a), 32'd1);
      step_refs(6'b101000);
      chk("R8", 32'(sec_a), 32'd0);
      write_ctrl(32'd15 << 20);
      step_refs(6'b100000);
      step_refs(6'b010000);
      chk("R8", 32'(sec_a), 32'd1);
      step_refs(6'b010000);
      chk("R8", 32'(sec_a), 32'd0);
      // R6: falling edge of reference 4 also pulses in mode 10
      write_ctrl(32'd10 << 20);
      step_refs(6'b001000);
      chk("R6", 32'(sec_a), 32'd1);
      step_refs(6'b000000);
      chk("R6", 32'(sec_a), 32'd1);
      step_refs(6'b000000);
      chk("R6", 32'(sec_a), 32'd0);

      // R1: reset in the middle of activity
      write_ctrl((32'd9 << 20) | (32'd1 << 4));
      ev_en = 1'b1;
      refs = 6'h3F;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", 32'(pri_a), 32'd0);
      chk("R1", 32'(sec_a), 32'd0);
      chk("R1", rd_a, 32'd0);
      rst = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule